// File: doc/BRIEF.md
# DMA Channel Interrupt and Completion-Count Registers

This block holds the interrupt state of one DMA channel. The channel reports what happens through one-cycle event pulses, one per interrupt source. Each pulse sets a sticky status bit. Software reads the status and clears it by writing ones. A shared mask register decides which status bits reach the level interrupt line. Software cannot write the mask directly. It changes the mask only through two stateless strobe registers: one clears mask bits and the other sets them.

A small wrapping counter records how many transfers have finished and have not yet been acknowledged. The counter goes up on each completion event. It goes down when software clears a done status bit that was set. Software can also zero chosen counter bits by writing ones to them.

Registers are reached through a simple write port and a combinational read port, both selected by a 3-bit register index.

Top module: `irq_regs_top`

## Requirements
- R1: After reset the status reads 0x00, the mask reads 0xFF, the counter reads 0, and `irq` is low.
- R2: A pulse on `evt_i[k]` sets status bit k, and the bit stays set until software clears it. The bit order from 7 down to 0 is: FIFO overflow, invalid bus access, threshold hit, memory timeout, stream timeout, bus response error, done, memory done.
- R3: A write to index 0 (status) clears every status bit written as 1. Bits written as 0 are left unchanged.
- R4: A write to index 1 (enable) clears every mask bit written as 1. Reading index 1 returns zero.
- R5: A write to index 2 (disable) sets every mask bit written as 1. Reading index 2 returns zero.
- R6: Index 3 returns the mask. Writes to index 3 have no effect on any register.
- R7: `irq` is high exactly when some status bit is set and its mask bit is 0.
- R8: When an event pulse and a clearing write reach the same status bit in the same cycle, the bit ends up set.
- R9: The counter (index 4, bits 2:0) increments on each pulse of the done source (bit 1) and wraps modulo 8.
- R10: A status write with bit 1 set decrements the counter only if the done status bit was set before the write. The counter decrements by wrapping, so 0 goes to 7.
- R11: A write to index 4 clears the counter bits written as 1. A done event in the same cycle is added after that clear.
- R12: A done event in the same cycle as a status write that clears a set done bit leaves the counter unchanged, and the done bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 8 | One-cycle event pulses, one per interrupt source |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Index of the register being written |
| wr_data | input | 8 | Write data (all writable fields fit in 8 bits) |
| rd_sel | input | 3 | Index of the register being read |
| rd_data | output | 32 | Read data, zero-extended |
| irq | output | 1 | Level interrupt line |

## Verification
The hardest cases to reach are the same-cycle collisions. In one, a done event lands in the very cycle that a write acknowledges a set done bit. In the other, a counter-clear write coincides with a completion. Each requires an event pulse and a register write to meet at one clock edge. The bench drives both from one task at the same falling edge, so they meet at the next rising edge. It then reads the counter and the status to confirm that the event won and that the count moved by the right net amount. The counter wrap in both directions is reached by driving the count past 7 with done pulses. It is then acknowledged from zero.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;

    localparam int SRC_COUNT  = 8;
    localparam int DONE_CNT_W = 3;
    localparam int SEL_W      = 3;
    localparam int RD_W       = 32;

    // Source bit positions (priority-free; order is what software decodes)
    localparam int BIT_MEM_DONE   = 0;
    localparam int BIT_DONE       = 1;
    localparam int BIT_RESP_ERR   = 2;
    localparam int BIT_STRM_TO    = 3;
    localparam int BIT_MEM_TO     = 4;
    localparam int BIT_THRESH     = 5;
    localparam int BIT_BAD_ACCESS = 6;
    localparam int BIT_OVERFLOW   = 7;

    typedef enum logic [SEL_W-1:0] {
        SEL_STATUS  = 3'd0,
        SEL_ENABLE  = 3'd1,
        SEL_DISABLE = 3'd2,
        SEL_MASK    = 3'd3,
        SEL_COUNT   = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic status_w1c;
        logic mask_clr;
        logic mask_set;
        logic count_w1c;
    } wr_strobe_t;

    function automatic wr_strobe_t decode_write(input logic en, input logic [SEL_W-1:0] sel);
        wr_strobe_t s;
        s = '0;
        if (en) begin
            case (reg_sel_e'(sel))
                SEL_STATUS:  s.status_w1c = 1'b1;
                SEL_ENABLE:  s.mask_clr   = 1'b1;
                SEL_DISABLE: s.mask_set   = 1'b1;
                SEL_COUNT:   s.count_w1c  = 1'b1;
                default:     s            = '0;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int N = irq_regs_pkg::SRC_COUNT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt,
    input  logic         clr_stb,
    input  logic [N-1:0] clr_bits,
    output logic [N-1:0] status
);

    // One sticky cell per source; a same-cycle event beats the clear.
    for (genvar i = 0; i < N; i++) begin : g_cell
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                bit_q <= 1'b0;
            end else if (evt[i]) begin
                bit_q <= 1'b1;
            end else if (clr_stb && clr_bits[i]) begin
                bit_q <= 1'b0;
            end
        end
        assign status[i] = bit_q;
    end

endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
    parameter int N = irq_regs_pkg::SRC_COUNT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_stb,
    input  logic         clr_stb,
    input  logic [N-1:0] bits,
    output logic [N-1:0] mask
);

    logic [N-1:0] mask_q;
    logic [N-1:0] mask_d;

    always_comb begin
        mask_d = mask_q;
        if (set_stb) begin
            mask_d = mask_q | bits;
        end else if (clr_stb) begin
            mask_d = mask_q & ~bits;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
        end else begin
            mask_q <= mask_d;
        end
    end

    assign mask = mask_q;

endmodule

// File: rtl/irq_done_counter.sv
module irq_done_counter #(
    parameter int W = irq_regs_pkg::DONE_CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         dec,
    input  logic         clr_stb,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] count
);

    logic [W-1:0] cnt_q;
    logic [W-1:0] base;
    logic [W-1:0] cnt_d;

    // Bit clear first, then the net of increment and decrement, modulo 2**W.
    always_comb begin
        base  = clr_stb ? (cnt_q & ~clr_bits) : cnt_q;
        cnt_d = base + {{(W-1){1'b0}}, inc} - {{(W-1){1'b0}}, dec};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux #(
    parameter int N    = irq_regs_pkg::SRC_COUNT,
    parameter int W    = irq_regs_pkg::DONE_CNT_W,
    parameter int SELW = irq_regs_pkg::SEL_W,
    parameter int RDW  = irq_regs_pkg::RD_W
) (
    input  logic [SELW-1:0] sel,
    input  logic [N-1:0]    status,
    input  logic [N-1:0]    mask,
    input  logic [W-1:0]    count,
    output logic [RDW-1:0]  data
);
    import irq_regs_pkg::*;

    always_comb begin
        data = '0;
        case (reg_sel_e'(sel))
            SEL_STATUS: data = {{(RDW-N){1'b0}}, status};
            SEL_MASK:   data = {{(RDW-N){1'b0}}, mask};
            SEL_COUNT:  data = {{(RDW-W){1'b0}}, count};
            default:    data = '0;
        endcase
    end

endmodule

// File: rtl/irq_regs_top.sv
module irq_regs_top
    import irq_regs_pkg::*;
#(
    parameter int NUM_SRC  = SRC_COUNT,
    parameter int CNT_W    = DONE_CNT_W,
    parameter int DONE_BIT = BIT_DONE
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [NUM_SRC-1:0] wr_data,
    input  logic [SEL_W-1:0]   rd_sel,
    output logic [RD_W-1:0]    rd_data,
    output logic               irq
);

    wr_strobe_t         stb;
    logic [NUM_SRC-1:0] status_q;
    logic [NUM_SRC-1:0] mask_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               done_ack;

    assign stb = decode_write(wr_en, wr_sel);

    irq_status_bank #(.N(NUM_SRC)) u_status (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt_i),
        .clr_stb  (stb.status_w1c),
        .clr_bits (wr_data),
        .status   (status_q)
    );

    irq_mask_bank #(.N(NUM_SRC)) u_mask (
        .clk     (clk),
        .rst     (rst),
        .set_stb (stb.mask_set),
        .clr_stb (stb.mask_clr),
        .bits    (wr_data),
        .mask    (mask_q)
    );

    // Acknowledge counts only when the done bit was actually set.
    assign done_ack = stb.status_w1c && wr_data[DONE_BIT] && status_q[DONE_BIT];

    irq_done_counter #(.W(CNT_W)) u_count (
        .clk      (clk),
        .rst      (rst),
        .inc      (evt_i[DONE_BIT]),
        .dec      (done_ack),
        .clr_stb  (stb.count_w1c),
        .clr_bits (wr_data[CNT_W-1:0]),
        .count    (cnt_q)
    );

    irq_read_mux #(.N(NUM_SRC), .W(CNT_W), .SELW(SEL_W), .RDW(RD_W)) u_rd (
        .sel    (rd_sel),
        .status (status_q),
        .mask   (mask_q),
        .count  (cnt_q),
        .data   (rd_data)
    );

    assign irq = |(status_q & ~mask_q);

endmodule

// File: rtl/irq_regs_chk.sv
module irq_regs_chk
    import irq_regs_pkg::*;
#(
    parameter int N        = SRC_COUNT,
    parameter int W        = DONE_CNT_W,
    parameter int DONE_BIT = BIT_DONE
) (
    input logic             clk,
    input logic             rst,
    input logic [N-1:0]     evt_i,
    input logic             wr_en,
    input logic [SEL_W-1:0] wr_sel,
    input logic [N-1:0]     wr_data,
    input logic             irq,
    input logic [N-1:0]     status_q,
    input logic [N-1:0]     mask_q,
    input logic [W-1:0]     cnt_q
);

    // R2 R8
    evt_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_i != '0) |=> ((status_q & $past(evt_i)) == $past(evt_i)));

    // R3
    status_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_sel == SEL_STATUS) |=> (status_q == ($past(status_q) | $past(evt_i))));

    // R4
    enable_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_ENABLE) |=> ((mask_q & $past(wr_data)) == '0));

    // R5
    disable_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_DISABLE) |=> ((mask_q & $past(wr_data)) == $past(wr_data)));

    // R6
    mask_ro_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && (wr_sel == SEL_ENABLE || wr_sel == SEL_DISABLE)) |=> $stable(mask_q));

    // R7
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ((mask_q == '1) || (status_q == '0)) |-> !irq);

    // R9
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!evt_i[DONE_BIT] && !(wr_en && (wr_sel == SEL_STATUS || wr_sel == SEL_COUNT)))
        |=> $stable(cnt_q));

endmodule

bind irq_regs_top irq_regs_chk #(.N(NUM_SRC), .W(CNT_W), .DONE_BIT(DONE_BIT)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .evt_i    (evt_i),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .irq      (irq),
    .status_q (status_q),
    .mask_q   (mask_q),
    .cnt_q    (cnt_q)
);

// File: tb/sim_irq_regs_top.sv
`timescale 1ns/1ps
module sim_irq_regs_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  evt_i = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [7:0]  wr_data = '0;
    logic [2:0]  rd_sel = '0;
    logic [31:0] rd_data;
    logic        irq;

    int checks = 0;
    int errors = 0;

    localparam logic [2:0] I_STAT = 3'd0, I_EN = 3'd1, I_DIS = 3'd2, I_MASK = 3'd3, I_CNT = 3'd4;

    always #2.5 clk = ~clk;

    irq_regs_top u0 (
        .clk(clk), .rst(rst), .evt_i(evt_i), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] s, output logic [31:0] v);
        rd_sel = s;
        #0.5;
        v = rd_data;
    endtask

    task automatic cycle(input logic [7:0] e, input logic we, input logic [2:0] s, input logic [7:0] d);
        @(negedge clk);
        evt_i = e; wr_en = we; wr_sel = s; wr_data = d;
        @(negedge clk);
        evt_i = '0; wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic expect_reg(input string req, input logic [2:0] s, input logic [31:0] exp);
        logic [31:0] v;
        rd(s, v);
        check(req, v, exp);
    endtask

    task automatic t_reset;
        expect_reg("R1 status", I_STAT, 32'h00);
        expect_reg("R1 mask", I_MASK, 32'hFF);
        expect_reg("R1 count", I_CNT, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_sticky;
        cycle(8'h84, 1'b0, I_STAT, 8'h00);
        expect_reg("R2 set", I_STAT, 32'h84);
        cycle(8'h00, 1'b0, I_STAT, 8'h00);
        cycle(8'h00, 1'b0, I_STAT, 8'h00);
        expect_reg("R2 sticky", I_STAT, 32'h84);
        check("R7 masked", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_clear;
        cycle(8'h00, 1'b1, I_STAT, 8'h04);
        expect_reg("R3 w1c", I_STAT, 32'h80);
        cycle(8'h00, 1'b1, I_STAT, 8'h00);
        expect_reg("R3 w0 no effect", I_STAT, 32'h80);
        cycle(8'h00, 1'b1, I_STAT, 8'h80);
        expect_reg("R3 cleared", I_STAT, 32'h00);
    endtask

    task automatic t_mask;
        cycle(8'h00, 1'b1, I_EN, 8'h0F);
        expect_reg("R4 enable", I_MASK, 32'hF0);
        expect_reg("R4 reads zero", I_EN, 32'h0);
        cycle(8'h00, 1'b1, I_DIS, 8'h03);
        expect_reg("R5 disable", I_MASK, 32'hF3);
        expect_reg("R5 reads zero", I_DIS, 32'h0);
        cycle(8'h00, 1'b1, I_MASK, 8'h00);
        expect_reg("R6 mask ro", I_MASK, 32'hF3);
        expect_reg("R6 status untouched", I_STAT, 32'h00);
        expect_reg("R6 count untouched", I_CNT, 32'h0);
    endtask

    task automatic t_irq;
        cycle(8'h80, 1'b0, I_STAT, 8'h00);
        check("R7 masked source", {31'b0, irq}, 32'h0);
        cycle(8'h04, 1'b0, I_STAT, 8'h00);
        check("R7 open source", {31'b0, irq}, 32'h1);
        cycle(8'h00, 1'b1, I_DIS, 8'h04);
        check("R7 disabled", {31'b0, irq}, 32'h0);
        cycle(8'h00, 1'b1, I_EN, 8'h04);
        check("R7 re-enabled", {31'b0, irq}, 32'h1);
        cycle(8'h00, 1'b1, I_STAT, 8'h84);
        check("R7 after clear", {31'b0, irq}, 32'h0);
        cycle(8'h00, 1'b1, I_DIS, 8'hFF);
    endtask

    task automatic t_collision;
        cycle(8'h20, 1'b1, I_STAT, 8'h20);
        expect_reg("R8 event wins", I_STAT, 32'h20);
        cycle(8'h00, 1'b1, I_STAT, 8'h20);
        expect_reg("R8 then clears", I_STAT, 32'h00);
    endtask

    task automatic t_count;
        for (int i = 0; i < 3; i++) cycle(8'h02, 1'b0, I_STAT, 8'h00);
        expect_reg("R9 count 3", I_CNT, 32'h3);
        expect_reg("R2 done bit", I_STAT, 32'h02);
        cycle(8'h00, 1'b1, I_STAT, 8'h02);
        expect_reg("R10 decrement", I_CNT, 32'h2);
        cycle(8'h00, 1'b1, I_STAT, 8'h02);
        expect_reg("R10 no decrement when clear", I_CNT, 32'h2);
        for (int i = 0; i < 6; i++) cycle(8'h02, 1'b0, I_STAT, 8'h00);
        expect_reg("R9 wrap to 0", I_CNT, 32'h0);
        cycle(8'h00, 1'b1, I_STAT, 8'h02);
        expect_reg("R10 wrap to 7", I_CNT, 32'h7);
    endtask

    task automatic t_count_w1c;
        cycle(8'h00, 1'b1, I_CNT, 8'h05);
        expect_reg("R11 bit clear", I_CNT, 32'h2);
        cycle(8'h00, 1'b1, I_CNT, 8'h00);
        expect_reg("R11 w0 no effect", I_CNT, 32'h2);
        cycle(8'h02, 1'b1, I_CNT, 8'h02);
        expect_reg("R11 clear then add", I_CNT, 32'h1);
        cycle(8'h02, 1'b1, I_STAT, 8'h02);
        expect_reg("R12 count unchanged", I_CNT, 32'h1);
        expect_reg("R12 done stays", I_STAT, 32'h02);
        cycle(8'h00, 1'b1, I_STAT, 8'h02);
        expect_reg("R10 final ack", I_CNT, 32'h0);
        expect_reg("R3 final status", I_STAT, 32'h00);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_sticky();
        t_clear();
        t_mask();
        t_irq();
        t_collision();
        t_count();
        t_count_w1c();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule